// File: doc/BRIEF.md
# Speculative Instruction Word Fetch Requester

This block sits between a processor front end and a read-only instruction memory port. After the core names a start or branch target, the block runs ahead through the code one word at a time. It raises read requests for successive word addresses and passes each returned word, together with its error flag, into a downstream alignment buffer that holds three words. Every request carries memory-type attributes (cacheable, bufferable), protection attributes and a debug-mode flag. These are sampled from configuration inputs when the request is formed.

The block counts the words sitting in the downstream buffer and the transactions that have been granted but not yet answered. It only starts a new request while their sum leaves room for one more word, and never while two transactions are already in flight. Responses come back in issue order. When the core redirects, the buffer is emptied. Every transaction from the old stream, including a request that is still waiting for its grant, is counted off, and its response is discarded. Fetching then resumes at the new target.

Top module: `ifetch_issuer`

## Requirements
- R1: After reset `memReq` and `wordValid` are low, and no request is raised until the first redirect.
- R2: The first request after a redirect is raised two clock edges after `redirValid` is sampled high, at the target address with bits [1:0] forced to zero; `memAddr[1:0]` is always zero.
- R3: Each further request uses the address of the previously issued request plus 4.
- R4: While `memReq` is high and `memGnt` is low, `memReq` stays high and `memAddr`, `memType`, `memProt` and `memDbg` stay unchanged at the next edge, even if the configuration inputs change.
- R5: No more than two transactions are granted and unanswered at any time; with two in flight `memReq` stays low.
- R6: A new request is raised only when the buffered word count plus the unanswered count is below three; a `wordPop` pulse frees one buffer slot and lets fetching resume.
- R7: A response that is not stale appears in the same cycle as `memRvalid`: `wordValid` high, with `wordData` equal to `memRdata` and `wordErr` equal to `memErr`.
- R8: Responses to transactions granted before a redirect, and any response arriving in the redirect cycle itself, produce no `wordValid`.
- R9: `memType` (bit 0 cacheable, bit 1 bufferable), `memProt` and `memDbg` equal the values of `cfgType`, `cfgProt` and `cfgDbg` at the edge where the request was formed.
- R10: A redirect that arrives while a request is waiting for its grant leaves that request raised and unchanged until granted; its response is dropped, and the target request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| redirValid | input | 1 | Redirect strobe from the core |
| redirAddr | input | 32 | Redirect target (byte address) |
| cfgType | input | 2 | Memory-type attributes for new requests |
| cfgProt | input | 3 | Protection attributes for new requests |
| cfgDbg | input | 1 | Debug-mode flag for new requests |
| memReq | output | 1 | Read request valid |
| memGnt | input | 1 | Request accepted by memory |
| memAddr | output | 32 | Word-aligned request address |
| memType | output | 2 | Memory-type attributes of the request |
| memProt | output | 3 | Protection attributes of the request |
| memDbg | output | 1 | Debug-mode flag of the request |
| memRvalid | input | 1 | Response valid |
| memRdata | input | 32 | Response data |
| memErr | input | 1 | Response error flag |
| wordValid | output | 1 | Word forwarded to the buffer this cycle |
| wordData | output | 32 | Forwarded word |
| wordErr | output | 1 | Error flag of the forwarded word |
| wordPop | input | 1 | Downstream buffer consumed one word |

## Verification
The bench holds back grants for several cycles while the configuration inputs change. A design that re-samples or advances during that wait would move the address or attributes of a request that is still pending. It fills the buffer until the occupancy limit is reached and then releases it with a pop; a design that counts only one of the two quantities would over-issue, or would stall for good. It redirects while one transaction is in flight and another is still waiting for its grant, and also in the very cycle a response returns. A design that forgets the held request, or that forwards a response from the same cycle, would leak stale words into the new stream or would never issue the target fetch.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic issue;       // form a new request from the sequential pointer
    logic loadTarget;  // replace the sequential pointer with the redirect target
  } fetchStrobe_t;
endpackage

// File: rtl/ifetch_dp.sv
module ifetch_dp
  import ifetch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TYPE_W = 2,
  parameter int PROT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  fetchStrobe_t      strobe,
  input  logic [ADDR_W-1:0] redirAddr,
  input  logic [TYPE_W-1:0] cfgType,
  input  logic [PROT_W-1:0] cfgProt,
  input  logic              cfgDbg,
  input  logic              reqLive,
  input  logic              memGnt,
  output logic [ADDR_W-1:0] memAddr,
  output logic [TYPE_W-1:0] memType,
  output logic [PROT_W-1:0] memProt,
  output logic              memDbg
);
  localparam int WORD_BYTES = 4;
  localparam int LOW_BITS   = $clog2(WORD_BYTES);

  logic [ADDR_W-1:0] seqAddr;
  logic [ADDR_W-1:0] addrQ;
  logic [TYPE_W-1:0] typeQ;
  logic [PROT_W-1:0] protQ;
  logic              dbgQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqAddr <= '0;
      addrQ   <= '0;
      typeQ   <= '0;
      protQ   <= '0;
      dbgQ    <= 1'b0;
    end else begin
      if (strobe.loadTarget) begin
        seqAddr <= {redirAddr[ADDR_W-1:LOW_BITS], {LOW_BITS{1'b0}}};
      end else if (strobe.issue) begin
        seqAddr <= seqAddr + ADDR_W'(WORD_BYTES);
      end
      if (strobe.issue) begin
        addrQ <= seqAddr;
        typeQ <= cfgType;
        protQ <= cfgProt;
        dbgQ  <= cfgDbg;
      end
    end
  end

  assign memAddr = addrQ;
  assign memType = typeQ;
  assign memProt = protQ;
  assign memDbg  = dbgQ;

  // R2
  word_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    memAddr[LOW_BITS-1:0] == '0);

  // R4
  held_fields_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqLive && !memGnt) |=> ($stable(memAddr) && $stable(memType) &&
                              $stable(memProt) && $stable(memDbg)));
endmodule

// File: rtl/ifetch_ctl.sv
module ifetch_ctl
  import ifetch_pkg::*;
#(
  parameter int BUF_DEPTH = 3,
  parameter int MAX_OUT   = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         redirValid,
  input  logic         memGnt,
  input  logic         memRvalid,
  input  logic         wordPop,
  output logic         memReq,
  output logic         wordValid,
  output fetchStrobe_t strobe
);
  localparam int CNT_W = $clog2(BUF_DEPTH + MAX_OUT + 1);

  logic             reqQ;
  logic             running;
  logic             staleQ;
  logic [CNT_W-1:0] outCnt;
  logic [CNT_W-1:0] dropCnt;
  logic [CNT_W-1:0] occ;

  logic             grant, holdReq, fwd, dropHit, popOk, issue;
  logic [CNT_W-1:0] outNext, occNext, dropNext;
  logic             staleNext;

  always_comb begin
    grant     = reqQ & memGnt;
    holdReq   = reqQ & ~memGnt;
    fwd       = memRvalid & (dropCnt == '0) & ~redirValid;
    dropHit   = memRvalid & (dropCnt != '0) & ~redirValid;
    popOk     = wordPop & (occ != '0);
    outNext   = outCnt + CNT_W'(grant) - CNT_W'(memRvalid);
    occNext   = redirValid ? '0 : occ + CNT_W'(fwd) - CNT_W'(popOk);
    dropNext  = redirValid ? outNext
                           : dropCnt + CNT_W'(staleQ & grant) - CNT_W'(dropHit);
    staleNext = redirValid ? holdReq : (staleQ & ~grant);
    issue     = running & ~holdReq & ~redirValid &
                ((occNext + outNext) < CNT_W'(BUF_DEPTH)) &
                (outNext < CNT_W'(MAX_OUT));
    strobe.issue      = issue;
    strobe.loadTarget = redirValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ    <= 1'b0;
      running <= 1'b0;
      staleQ  <= 1'b0;
      outCnt  <= '0;
      dropCnt <= '0;
      occ     <= '0;
    end else begin
      reqQ    <= holdReq | issue;
      running <= running | redirValid;
      staleQ  <= staleNext;
      outCnt  <= outNext;
      dropCnt <= dropNext;
      occ     <= occNext;
    end
  end

  assign memReq    = reqQ;
  assign wordValid = fwd;

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memGnt) |=> memReq);

  // R5
  inflight_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    outCnt <= CNT_W'(MAX_OUT));

  // R6
  capacity_chk: assert property (@(posedge clk) disable iff (!rstN)
    (occ + outCnt) <= CNT_W'(BUF_DEPTH));

  // R1
  idle_before_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> !memReq);

  // R8
  redirect_silence_chk: assert property (@(posedge clk) disable iff (!rstN)
    redirValid |-> !wordValid);
endmodule

// File: rtl/ifetch_issuer.sv
module ifetch_issuer
  import ifetch_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int TYPE_W    = 2,
  parameter int PROT_W    = 3,
  parameter int BUF_DEPTH = 3,
  parameter int MAX_OUT   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              redirValid,
  input  logic [ADDR_W-1:0] redirAddr,
  input  logic [TYPE_W-1:0] cfgType,
  input  logic [PROT_W-1:0] cfgProt,
  input  logic              cfgDbg,
  output logic              memReq,
  input  logic              memGnt,
  output logic [ADDR_W-1:0] memAddr,
  output logic [TYPE_W-1:0] memType,
  output logic [PROT_W-1:0] memProt,
  output logic              memDbg,
  input  logic              memRvalid,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memErr,
  output logic              wordValid,
  output logic [DATA_W-1:0] wordData,
  output logic              wordErr,
  input  logic              wordPop
);
  fetchStrobe_t strobe;

  ifetch_ctl #(.BUF_DEPTH(BUF_DEPTH), .MAX_OUT(MAX_OUT)) ctl (
    .clk(clk), .rstN(rstN), .redirValid(redirValid), .memGnt(memGnt),
    .memRvalid(memRvalid), .wordPop(wordPop), .memReq(memReq),
    .wordValid(wordValid), .strobe(strobe)
  );

  ifetch_dp #(.ADDR_W(ADDR_W), .TYPE_W(TYPE_W), .PROT_W(PROT_W)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .redirAddr(redirAddr),
    .cfgType(cfgType), .cfgProt(cfgProt), .cfgDbg(cfgDbg),
    .reqLive(memReq), .memGnt(memGnt), .memAddr(memAddr),
    .memType(memType), .memProt(memProt), .memDbg(memDbg)
  );

  // R7: in-order responses pass straight through
  assign wordData = memRdata;
  assign wordErr  = memErr;
endmodule

// File: tb/ifetch_issuer_test.sv
module ifetch_issuer_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic        redirValid, cfgDbg, memGnt, memRvalid, memErr, wordPop;
  logic [31:0] redirAddr, memRdata, memAddr, wordData;
  logic [1:0]  cfgType, memType;
  logic [2:0]  cfgProt, memProt;
  logic        memReq, memDbg, wordValid, wordErr;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  ifetch_issuer uut (
    .clk(clk), .rstN(rstN), .redirValid(redirValid), .redirAddr(redirAddr),
    .cfgType(cfgType), .cfgProt(cfgProt), .cfgDbg(cfgDbg),
    .memReq(memReq), .memGnt(memGnt), .memAddr(memAddr), .memType(memType),
    .memProt(memProt), .memDbg(memDbg), .memRvalid(memRvalid),
    .memRdata(memRdata), .memErr(memErr), .wordValid(wordValid),
    .wordData(wordData), .wordErr(wordErr), .wordPop(wordPop)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // advance one edge; inputs were set before, outputs settle 1ns later
  task automatic edge1();
    @(posedge clk);
    #1;
  endtask

  task automatic quiet();
    redirValid = 0; memGnt = 0; memRvalid = 0; memErr = 0; wordPop = 0;
    memRdata = '0;
  endtask

  task automatic doReset();
    quiet();
    redirAddr = '0; cfgType = 2'b01; cfgProt = 3'b010; cfgDbg = 0;
    rstN = 0;
    edge1(); edge1();
    rstN = 1;
    edge1();
  endtask

  task automatic startAt(input logic [31:0] target);
    redirValid = 1; redirAddr = target;
    edge1();
    redirValid = 0;
    edge1();
  endtask

  task automatic testReset();
    doReset();
    check("R1 req after reset", 32'(memReq), 0);
    check("R1 valid after reset", 32'(wordValid), 0);
    edge1(); edge1();
    check("R1 idle without redirect", 32'(memReq), 0);
  endtask

  task automatic testStreamAndThrottle();
    doReset();
    cfgType = 2'b11; cfgProt = 3'b101; cfgDbg = 1;
    startAt(32'h0000_1006);
    check("R2 req after redirect", 32'(memReq), 1);
    check("R2 aligned target", memAddr, 32'h0000_1004);
    check("R9 type sampled", 32'(memType), 32'h3);
    check("R9 prot sampled", 32'(memProt), 32'h5);
    check("R9 dbg sampled", 32'(memDbg), 1);
    // hold without grant, change config
    cfgType = 2'b00; cfgProt = 3'b000; cfgDbg = 0;
    edge1(); edge1(); edge1();
    check("R4 req held", 32'(memReq), 1);
    check("R4 addr held", memAddr, 32'h0000_1004);
    check("R4 type held", 32'(memType), 32'h3);
    check("R4 dbg held", 32'(memDbg), 1);
    memGnt = 1;
    edge1();
    check("R3 next addr", memAddr, 32'h0000_1008);
    check("R9 new attrs", 32'(memProt), 32'h0);
    edge1();
    memGnt = 0;
    check("R5 two in flight stops req", 32'(memReq), 0);
    edge1();
    check("R5 still stopped", 32'(memReq), 0);
    memRvalid = 1; memRdata = 32'hAAAA_0001; memErr = 0;
    #1;
    check("R7 valid", 32'(wordValid), 1);
    check("R7 data", wordData, 32'hAAAA_0001);
    edge1();
    check("R3 third addr", memAddr, 32'h0000_100C);
    check("R6 issue with room", 32'(memReq), 1);
    memRdata = 32'hBBBB_0002; memErr = 1;
    #1;
    check("R7 err forwarded", 32'(wordErr), 1);
    check("R7 data 2", wordData, 32'hBBBB_0002);
    edge1();
    memRvalid = 0; memErr = 0;
    memGnt = 1;
    edge1();
    memGnt = 0;
    check("R6 full stops req", 32'(memReq), 0);
    edge1();
    check("R6 still full", 32'(memReq), 0);
    wordPop = 1;
    edge1();
    wordPop = 0;
    check("R6 pop resumes", 32'(memReq), 1);
    check("R3 fourth addr", memAddr, 32'h0000_1010);
  endtask

  task automatic testRedirectDrop();
    // continues from the previous state: 0x100C in flight, 0x1010 waiting
    redirValid = 1; redirAddr = 32'h0000_2003;
    edge1();
    redirValid = 0;
    check("R10 held req stays", 32'(memReq), 1);
    check("R10 held addr", memAddr, 32'h0000_1010);
    memGnt = 1;
    edge1();
    memGnt = 0;
    check("R5 stale pair blocks issue", 32'(memReq), 0);
    memRvalid = 1; memRdata = 32'hDEAD_0001;
    #1;
    check("R8 stale one dropped", 32'(wordValid), 0);
    edge1();
    check("R2 target after drops", memAddr, 32'h0000_2000);
    check("R10 target req raised", 32'(memReq), 1);
    memRdata = 32'hDEAD_0002;
    #1;
    check("R10 held response dropped", 32'(wordValid), 0);
    edge1();
    memRvalid = 0;
    memGnt = 1;
    edge1();
    memGnt = 0;
    check("R3 after target", memAddr, 32'h0000_2004);
    memRvalid = 1; memRdata = 32'hC0DE_0003;
    #1;
    check("R7 new stream forwarded", 32'(wordValid), 1);
    check("R7 new stream data", wordData, 32'hC0DE_0003);
    edge1();
    memRvalid = 0;
  endtask

  task automatic testRedirectSameCycle();
    doReset();
    startAt(32'h0000_3000);
    memGnt = 1;
    edge1();
    memGnt = 0;
    edge1();
    // response arrives together with a redirect
    memRvalid = 1; memRdata = 32'h1234_5678; redirValid = 1; redirAddr = 32'h0000_4000;
    #1;
    check("R8 same-cycle response dropped", 32'(wordValid), 0);
    edge1();
    memRvalid = 0; redirValid = 0;
    edge1();
    check("R8 waiting req for old stream", memAddr, 32'h0000_3004);
    memGnt = 1;
    edge1();
    memGnt = 0;
    memRvalid = 1; memRdata = 32'h5555_5555;
    #1;
    check("R8 stale follow-up dropped", 32'(wordValid), 0);
    edge1();
    memRvalid = 0;
    check("R2 resume at new target", memAddr, 32'h0000_4000);
    check("R2 req raised", 32'(memReq), 1);
  endtask

  initial begin
    fork
      begin
        testReset();
        testStreamAndThrottle();
        testRedirectDrop();
        testRedirectSameCycle();
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule